// File: doc/BRIEF.md
# Clock Source Switch Controller

This block owns a 16-bit oscillator control register. Through it, software picks which of eight clock sources the chip should run from and asks for a move to that source. The block checks each request against two rules. The first is a configuration lock that a board-level input can make binding. The second is a ban on jumping straight between the two PLL-based sources. A request that passes waits a fixed settle time and then drives the new code on a 3-bit source-select output. A request that fails leaves the source alone and gives a one-cycle error pulse.

Writes to the register are guarded by a two-key unlock sequence on a separate strobe. The register also reports a sticky clock-fail flag, set by a fail-safe monitor input and cleared by software. It also reports a PLL-lock flag taken from the PLL status inputs. Only the power-on reset touches the register. On that reset, both the current and the requested source load from a configuration input.

Top module: `clk_switch_ctrl`

## Requirements
- R1: While `por_n` is low, the current-source field and `src_sel_o` are set to `cfg_src_i`, and so is the new-source field. The lock bit, the fail flag, the switch-enable bit and `switch_err_o` are cleared.
- R2: Register layout of `reg_rdata_o`:
  - bits 14:12: current source
  - bits 10:8: new source
  - bit 7: lock
  - bit 5: PLL lock
  - bit 3: clock fail
  - bit 0: switch enable
  - bits 15, 11, 6, 4, 2 and 1 read as 0.
- R3: `reg_wr_i` takes effect only in the cycle that directly follows a key write of `KEY_FIRST` (8'hC3) and then a key write of `KEY_SECOND` (8'h3C) on two consecutive cycles. Any other write is ignored.
- R4: Software starts a switch by writing bit 0 = 1 together with the target in bits 10:8. If the switch is accepted, `src_sel_o` and bits 14:12 take the target on the fifth rising edge after the write edge, and bit 0 clears on that same edge. Codes are:
  - 000: fast RC
  - 001: fast RC with PLL
  - 010: primary
  - 011: primary with PLL
  - 100: secondary
  - 101: low-power RC
  - 110: fast RC divided by 16
  - 111: fast RC divided by n
- R5: A request from 011 to 001, or from 001 to 011, is refused. Bit 0 clears on the first edge after the write edge, the source stays unchanged, and `switch_err_o` is high for exactly the following cycle.
- R6: When bit 7 is 1 and `lock_honor_i` is 1, writes leave bits 10:8, bit 7 and bit 0 unchanged. When `lock_honor_i` is 0, those fields stay writable.
- R7: The fail flag (bit 3) is set by `fail_det_i`. An unlocked write with bit 3 = 0 clears it. A write with bit 3 = 1 has no effect. If detection and clear happen in the same cycle, detection wins.
- R8: Bit 5 reads 1 when `pll_locked_i` or `pll_timer_done_i` is 1, and 0 otherwise.
- R9: While a switch is pending (bit 0 = 1), writes leave bits 10:8 and bit 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| cfg_src_i | input | 3 | Source code loaded at power-on reset |
| lock_honor_i | input | 1 | Makes the lock bit binding when 1 |
| key_wr_i | input | 1 | Unlock key strobe |
| key_i | input | 8 | Unlock key value |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| fail_det_i | input | 1 | Clock-fail detection from the monitor |
| pll_locked_i | input | 1 | PLL reports lock |
| pll_timer_done_i | input | 1 | PLL start-up timer expired |
| src_sel_o | output | 3 | Selected clock source code |
| switch_err_o | output | 1 | One-cycle pulse on a refused switch |

## Verification
The hardest cases to reach are a second write that lands while an accepted switch is still settling, and a refused PLL-to-PLL move. The first needs a complete unlock-and-write sequence to fit inside the settle window. The second needs the current source to be a PLL source, which can only be reached through an earlier legal switch. A walked vector table takes the source through 000, 001, 011 and back, so both refusal directions are met. A directed test then starts a switch and at once repeats the unlock sequence to land a write mid-settle.

// File: rtl/cksw_pkg.sv
package cksw_pkg;

    typedef enum logic [2:0] {
        SRC_FRC      = 3'b000,
        SRC_FRC_PLL  = 3'b001,
        SRC_PRI      = 3'b010,
        SRC_PRI_PLL  = 3'b011,
        SRC_SEC      = 3'b100,
        SRC_LPRC     = 3'b101,
        SRC_FRC_D16  = 3'b110,
        SRC_FRC_DN   = 3'b111
    } src_e;

    typedef struct packed {
        src_e cur;
        src_e nsrc;
        logic lock;
        logic cf;
        logic swen;
        logic err;
    } ctl_t;

    function automatic logic pll_hop(src_e a, src_e b);
        return (a == SRC_PRI_PLL && b == SRC_FRC_PLL) ||
               (a == SRC_FRC_PLL && b == SRC_PRI_PLL);
    endfunction

endpackage

// File: rtl/cksw_unlock.sv
module cksw_unlock #(
    parameter int          KW         = 8,
    parameter logic [KW-1:0] KEY_FIRST  = 8'hC3,
    parameter logic [KW-1:0] KEY_SECOND = 8'h3C
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          key_wr_i,
    input  logic [KW-1:0] key_i,
    output logic          open_o
);
    logic armed_d, armed_q;
    logic open_d,  open_q;

    always_comb begin
        armed_d = key_wr_i && (key_i == KEY_FIRST);
        open_d  = key_wr_i && (key_i == KEY_SECOND) && armed_q;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            armed_q <= 1'b0;
            open_q  <= 1'b0;
        end else begin
            armed_q <= armed_d;
            open_q  <= open_d;
        end
    end

    assign open_o = open_q;
endmodule

// File: rtl/cksw_settle.sv
module cksw_settle #(
    parameter int SETTLE = 4,
    localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1
) (
    input  logic clk,
    input  logic por_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic          busy_d, busy_q;
    logic          last;

    always_comb begin
        last   = busy_q && (cnt_q == CW'(SETTLE - 1));
        cnt_d  = cnt_q;
        busy_d = busy_q;
        if (start_i && !busy_q) begin
            busy_d = 1'b1;
            cnt_d  = '0;
        end else if (last) begin
            busy_d = 1'b0;
            cnt_d  = '0;
        end else if (busy_q) begin
            cnt_d  = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            busy_q <= busy_d;
        end
    end

    assign busy_o = busy_q;
    assign done_o = last;
endmodule

// File: rtl/clk_switch_ctrl.sv
module clk_switch_ctrl
    import cksw_pkg::*;
#(
    parameter int          SETTLE     = 4,
    parameter int          KW         = 8,
    parameter logic [KW-1:0] KEY_FIRST  = 8'hC3,
    parameter logic [KW-1:0] KEY_SECOND = 8'h3C
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic [2:0]    cfg_src_i,
    input  logic          lock_honor_i,
    input  logic          key_wr_i,
    input  logic [KW-1:0] key_i,
    input  logic          reg_wr_i,
    input  logic [15:0]   reg_wdata_i,
    output logic [15:0]   reg_rdata_o,
    input  logic          fail_det_i,
    input  logic          pll_locked_i,
    input  logic          pll_timer_done_i,
    output logic [2:0]    src_sel_o,
    output logic          switch_err_o
);
    ctl_t r_d, r_q;
    logic win_open;
    logic tmr_start, tmr_busy, tmr_done;
    logic wr_ok, locked, refuse;
    logic unused_wbits;

    cksw_unlock #(.KW(KW), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_unlock (
        .clk      (clk),
        .por_n    (por_n),
        .key_wr_i (key_wr_i),
        .key_i    (key_i),
        .open_o   (win_open)
    );

    cksw_settle #(.SETTLE(SETTLE)) u_settle (
        .clk     (clk),
        .por_n   (por_n),
        .start_i (tmr_start),
        .busy_o  (tmr_busy),
        .done_o  (tmr_done)
    );

    always_comb begin
        r_d       = r_q;
        r_d.err   = 1'b0;
        wr_ok     = reg_wr_i && win_open;
        locked    = r_q.lock && lock_honor_i;
        refuse    = pll_hop(r_q.cur, r_q.nsrc);
        tmr_start = 1'b0;

        if (wr_ok && !locked) begin
            r_d.lock = reg_wdata_i[7];
            if (!r_q.swen) begin
                r_d.nsrc = src_e'(reg_wdata_i[10:8]);
                r_d.swen = reg_wdata_i[0];
            end
        end

        if (wr_ok && !reg_wdata_i[3]) r_d.cf = 1'b0;
        if (fail_det_i)               r_d.cf = 1'b1;

        if (r_q.swen && !tmr_busy) begin
            if (refuse) begin
                r_d.swen = 1'b0;
                r_d.err  = 1'b1;
            end else begin
                tmr_start = 1'b1;
            end
        end else if (tmr_done) begin
            r_d.cur  = r_q.nsrc;
            r_d.swen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            r_q.cur  <= src_e'(cfg_src_i);
            r_q.nsrc <= src_e'(cfg_src_i);
            r_q.lock <= 1'b0;
            r_q.cf   <= 1'b0;
            r_q.swen <= 1'b0;
            r_q.err  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign reg_rdata_o  = {1'b0, r_q.cur, 1'b0, r_q.nsrc, r_q.lock, 1'b0,
                           (pll_locked_i | pll_timer_done_i), 1'b0, r_q.cf,
                           2'b00, r_q.swen};
    assign src_sel_o    = r_q.cur;
    assign switch_err_o = r_q.err;
    assign unused_wbits = ^{reg_wdata_i[15:11], reg_wdata_i[6:4], reg_wdata_i[2:1]};
endmodule

// File: rtl/cksw_checker.sv
module cksw_checker (
    input logic        clk,
    input logic        por_n,
    input logic        lock_honor_i,
    input logic        fail_det_i,
    input logic [15:0] reg_rdata_o,
    input logic [2:0]  src_sel_o,
    input logic        switch_err_o
);
    // R4: the source moves only on the edge that retires a pending switch
    p_src_move_r4: assert property (@(posedge clk) disable iff (!por_n)
        (src_sel_o != $past(src_sel_o)) |-> ($past(reg_rdata_o[0]) && !reg_rdata_o[0]));

    // R5: the refusal error is a single-cycle pulse
    p_err_pulse_r5: assert property (@(posedge clk) disable iff (!por_n)
        switch_err_o |=> !switch_err_o);

    // R5: a refusal leaves the source where it was
    p_err_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
        switch_err_o |-> (src_sel_o == $past(src_sel_o)));

    // R6: a binding lock freezes the requested source
    p_lock_freeze_r6: assert property (@(posedge clk) disable iff (!por_n)
        (reg_rdata_o[7] && lock_honor_i) |=> $stable(reg_rdata_o[10:8]));

    // R7: detection always leaves the fail flag set
    p_cf_set_r7: assert property (@(posedge clk) disable iff (!por_n)
        fail_det_i |=> reg_rdata_o[3]);
endmodule

bind clk_switch_ctrl cksw_checker u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .lock_honor_i (lock_honor_i),
    .fail_det_i   (fail_det_i),
    .reg_rdata_o  (reg_rdata_o),
    .src_sel_o    (src_sel_o),
    .switch_err_o (switch_err_o)
);

// File: tb/sim_clk_switch_ctrl.sv
module sim_clk_switch_ctrl;
    localparam int PERIOD = 10;
    localparam logic [7:0] KA = 8'hC3;
    localparam logic [7:0] KB = 8'h3C;
    // each entry: {refused, target code}
    localparam logic [3:0] VEC [0:11] = '{
        4'b0_001, 4'b1_011, 4'b0_000, 4'b0_011, 4'b1_001, 4'b0_000,
        4'b0_110, 4'b0_111, 4'b0_101, 4'b0_100, 4'b0_010, 4'b0_010};

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic [2:0]  cfg_src = 3'b000;
    logic        lock_honor = 1'b0;
    logic        key_wr = 1'b0;
    logic [7:0]  key = 8'h00;
    logic        reg_wr = 1'b0;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;
    logic        fail_det = 1'b0;
    logic        pll_locked = 1'b0;
    logic        pll_timer = 1'b0;
    logic [2:0]  src_sel;
    logic        sw_err;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;
    logic [2:0] exp_cur;

    always #(PERIOD/2) clk = ~clk;

    clk_switch_ctrl u0 (
        .clk(clk), .por_n(por_n), .cfg_src_i(cfg_src), .lock_honor_i(lock_honor),
        .key_wr_i(key_wr), .key_i(key), .reg_wr_i(reg_wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .fail_det_i(fail_det), .pll_locked_i(pll_locked),
        .pll_timer_done_i(pll_timer), .src_sel_o(src_sel), .switch_err_o(sw_err));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // key pair then write in the open cycle; returns half a cycle after the write edge
    task automatic uwrite(input logic [15:0] d);
        @(negedge clk); key_wr = 1'b1; key = KA;
        @(negedge clk); key = KB;
        @(negedge clk); key_wr = 1'b0; key = 8'h00; reg_wr = 1'b1; wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    function automatic logic [15:0] req_word(input logic [2:0] src, input logic lk,
                                             input logic cfb, input logic en);
        return {5'b0, src, lk, 3'b0, cfb, 2'b0, en};
    endfunction

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        por_n = 1'b1;
        cyc(1);
        // R1: reset state
        chk("R1 src", {13'b0, src_sel}, 16'h0000);
        chk("R1 reg", rdata, 16'h0000);
        chk("R1 err", {15'b0, sw_err}, 16'h0000);

        // R8: PLL lock flag
        pll_locked = 1'b1; #1;
        chk("R8 locked", {15'b0, rdata[5]}, 16'h0001);
        pll_locked = 1'b0; pll_timer = 1'b1; #1;
        chk("R8 timer", {15'b0, rdata[5]}, 16'h0001);
        pll_timer = 1'b0; #1;
        chk("R8 none", {15'b0, rdata[5]}, 16'h0000);

        // R3: write without keys
        @(negedge clk); reg_wr = 1'b1; wdata = req_word(3'b101, 1'b0, 1'b1, 1'b0);
        @(negedge clk); reg_wr = 1'b0;
        chk("R3 nokey", {13'b0, rdata[10:8]}, 16'h0000);
        // R3: keys in wrong order
        @(negedge clk); key_wr = 1'b1; key = KB;
        @(negedge clk); key = KA;
        @(negedge clk); key_wr = 1'b0; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        chk("R3 order", {13'b0, rdata[10:8]}, 16'h0000);
        // R3: gap between keys
        @(negedge clk); key_wr = 1'b1; key = KA;
        @(negedge clk); key_wr = 1'b0;
        @(negedge clk); key_wr = 1'b1; key = KB;
        @(negedge clk); key_wr = 1'b0; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        chk("R3 gap", {13'b0, rdata[10:8]}, 16'h0000);
        // R3: write one cycle after the window
        @(negedge clk); key_wr = 1'b1; key = KA;
        @(negedge clk); key = KB;
        @(negedge clk); key_wr = 1'b0;
        @(negedge clk); reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        chk("R3 late", {13'b0, rdata[10:8]}, 16'h0000);
        // R3: correct sequence
        uwrite(req_word(3'b101, 1'b0, 1'b1, 1'b0));
        chk("R3 open", {13'b0, rdata[10:8]}, 16'h0005);
        uwrite(req_word(3'b000, 1'b0, 1'b1, 1'b0));

        // R4 / R5: walked switch table
        exp_cur = 3'b000;
        for (int v = 0; v < 12; v++) begin
            uwrite(req_word(VEC[v][2:0], 1'b0, 1'b1, 1'b1));
            if (VEC[v][3]) begin
                cyc(1);
                chk("R5 swen", {15'b0, rdata[0]}, 16'h0000);
                chk("R5 err", {15'b0, sw_err}, 16'h0001);
                chk("R5 src", {13'b0, src_sel}, {13'b0, exp_cur});
                cyc(1);
                chk("R5 pulse", {15'b0, sw_err}, 16'h0000);
            end else begin
                cyc(4);
                chk("R4 early", {13'b0, src_sel}, {13'b0, exp_cur});
                cyc(1);
                exp_cur = VEC[v][2:0];
                chk("R4 src", {13'b0, src_sel}, {13'b0, exp_cur});
                chk("R4 field", {13'b0, rdata[14:12]}, {13'b0, exp_cur});
                chk("R4 swen", {15'b0, rdata[0]}, 16'h0000);
            end
        end

        // R9: write during a pending switch
        uwrite(req_word(3'b000, 1'b0, 1'b1, 1'b1));
        uwrite(req_word(3'b101, 1'b0, 1'b1, 1'b1));
        chk("R9 nsrc", {13'b0, rdata[10:8]}, 16'h0000);
        cyc(2);
        chk("R9 src", {13'b0, src_sel}, 16'h0000);
        chk("R9 swen", {15'b0, rdata[0]}, 16'h0000);

        // R6: binding lock
        lock_honor = 1'b1;
        uwrite(req_word(3'b000, 1'b1, 1'b1, 1'b0));
        chk("R6 set", {15'b0, rdata[7]}, 16'h0001);
        uwrite(req_word(3'b110, 1'b0, 1'b1, 1'b1));
        cyc(6);
        chk("R6 src", {13'b0, src_sel}, 16'h0000);
        chk("R6 nsrc", {13'b0, rdata[10:8]}, 16'h0000);
        chk("R6 lock", {15'b0, rdata[7]}, 16'h0001);
        lock_honor = 1'b0;
        uwrite(req_word(3'b110, 1'b0, 1'b1, 1'b1));
        cyc(5);
        chk("R6 unbound", {13'b0, src_sel}, 16'h0006);
        chk("R6 clear", {15'b0, rdata[7]}, 16'h0000);

        // R7: clock-fail flag
        @(negedge clk); fail_det = 1'b1;
        @(negedge clk); fail_det = 1'b0;
        chk("R7 set", {15'b0, rdata[3]}, 16'h0001);
        uwrite(req_word(3'b110, 1'b0, 1'b1, 1'b0));
        chk("R7 one", {15'b0, rdata[3]}, 16'h0001);
        fail_det = 1'b1;
        uwrite(req_word(3'b110, 1'b0, 1'b0, 1'b0));
        fail_det = 1'b0;
        chk("R7 wins", {15'b0, rdata[3]}, 16'h0001);
        uwrite(req_word(3'b110, 1'b0, 1'b0, 1'b0));
        chk("R7 clear", {15'b0, rdata[3]}, 16'h0000);

        // R2: full readback layout
        pll_locked = 1'b1;
        uwrite(16'hFFFF);
        chk("R2 pending", rdata, 16'h67A1);
        cyc(5);
        chk("R2 done", rdata, 16'h77A0);
        pll_locked = 1'b0;

        // R1: power-on reset with a different configuration
        cfg_src = 3'b101;
        por_n = 1'b0;
        cyc(2);
        por_n = 1'b1;
        cyc(1);
        chk("R1 por src", {13'b0, src_sel}, 16'h0005);
        chk("R1 por reg", rdata, 16'h5500);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule